// File: doc/BRIEF.md
# Page Access Rights Checker

This block decides whether one memory access may proceed once a translation entry has been matched. It takes the entry's protection fields (two privilege bounds, a rights-type field and the dirty, break and reference-trap bits), the privilege level of the running code and the kind of access. From these it returns the set of rights the entry grants and, when the access may not proceed, a fault code. Privilege level 0 is the most privileged and the largest value is the least privileged.

The decision is made in combinational logic and captured in output registers. A request strobe loads the registers, so the response appears one clock later. Between strobes the registers keep their values. The fault code comes out either as a small binary number or as a one-hot vector; a parameter picks the form.

The dirty, break and reference-trap conditions are evaluated from lowest to highest priority. Each one removes rights from the granted set. When more than one applies, the later condition replaces the fault code set by an earlier one.

Top module: `par_checker`

## Requirements
- R1: The read right (grant bit 0) is present when the current privilege level is numerically at most the entry's first bound (`ent_pl_hi`).
- R2: The write right (grant bit 1) is present when the current privilege level is numerically at most the entry's second bound (`ent_pl_lo`).
- R3: The execute right (grant bit 2) is present only when `ent_pl_lo` is at most the current level and the current level is at most `ent_pl_hi`.
- R4: The rights type maps to rights as follows: 0 gives read; 1 gives read and write; 2 gives read and execute; 3 gives all three; any value from 4 upward gives execute only.
- R5: The access kind is encoded as 0 none, 1 read, 2 write, 3 execute. An access of kind none reports no fault. Its grant is the type mask from R4, with no pruning.
- R6: An access whose right is missing from the type mask faults, and the grant is the unpruned mask. The code is 1 for a denied execute. For a denied read or write, the code is 2 if read is in the mask and 3 if it is not.
- R7: When an access is permitted and the dirty bit is clear, a write faults with code 4. For every permitted access, write is removed from the grant.
- R8: When an access is permitted and the break bit is set, a write faults with code 5 and write is removed from the grant.
- R9: When an access is permitted and the reference-trap bit is set, a read or write faults with code 6 and only execute is kept in the grant. Priority runs from reference trap, then break, then dirty.
- R10: Outputs change only on the clock edge that samples `req_valid` high. `rsp_valid` is high for exactly the cycle after each strobe. Without a strobe, grant, fault and code hold their values.
- R11: After reset, `rsp_valid`, `rsp_grant`, `rsp_fault` and `rsp_code` are all zero. `rsp_fault` is high exactly when the code is nonzero.
- R12: With `FAULT_ONEHOT`=1, `rsp_code` is 6 bits wide. Bit (code-1) is set for a fault, and the vector is all zero when there is no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 0 none, 1 read, 2 write, 3 execute |
| cur_pl | input | PL_W | Current privilege level |
| ent_pl_hi | input | PL_W | Entry bound for read and the upper execute limit |
| ent_pl_lo | input | PL_W | Entry bound for write and the lower execute limit |
| ent_type | input | TYPE_W | Entry rights type |
| ent_dirty | input | 1 | Entry dirty bit |
| ent_break | input | 1 | Entry data-break bit |
| ent_reftrap | input | 1 | Entry reference-trap bit |
| rsp_valid | output | 1 | Response valid, one cycle after a strobe |
| rsp_grant | output | 3 | Granted rights: bit0 read, bit1 write, bit2 execute |
| rsp_fault | output | 1 | Fault present |
| rsp_code | output | FC_W (3, or 6 one-hot) | Fault code |

## Verification
The bench builds two instances side by side. One uses the defaults (2-bit privilege, 3-bit type, encoded fault code). The other uses `FAULT_ONEHOT`=1, so every case is checked in both code forms. With these widths the full input space is 16384 combinations, so an exhaustive sweep covers every bound ordering, every type code and every mix of the dirty, break and reference-trap bits. Random vectors interleaved with idle cycles then exercise the hold behaviour between strobes.

// File: rtl/par_pkg.sv
package par_pkg;
   localparam logic [1:0] KIND_NONE  = 2'd0;
   localparam logic [1:0] KIND_READ  = 2'd1;
   localparam logic [1:0] KIND_WRITE = 2'd2;
   localparam logic [1:0] KIND_EXEC  = 2'd3;

   localparam int RIGHT_R = 0;
   localparam int RIGHT_W = 1;
   localparam int RIGHT_X = 2;
   localparam int NUM_RIGHTS = 3;

   typedef enum logic [2:0] {
      FLT_NONE     = 3'd0,
      FLT_INST_PROT = 3'd1,
      FLT_DATA_PROT = 3'd2,
      FLT_RIGHTS   = 3'd3,
      FLT_DIRTY    = 3'd4,
      FLT_BREAK    = 3'd5,
      FLT_REFTRAP  = 3'd6
   } fault_e;

   localparam int NUM_FAULTS = 6;
endpackage

// File: rtl/par_rights_decode.sv
module par_rights_decode #(
   parameter int PL_W   = 2,
   parameter int TYPE_W = 3
) (
   input  logic [PL_W-1:0]   cur_pl,
   input  logic [PL_W-1:0]   pl_hi,
   input  logic [PL_W-1:0]   pl_lo,
   input  logic [TYPE_W-1:0] rtype,
   output logic [2:0]        type_mask
);
   import par_pkg::*;

   logic can_r, can_w, can_x, exec_only;

   assign can_r = (cur_pl <= pl_hi);
   assign can_w = (cur_pl <= pl_lo);
   assign can_x = (pl_lo <= cur_pl) && (cur_pl <= pl_hi);

   generate
      if (TYPE_W > 2) begin : g_wide_type
         assign exec_only = |rtype[TYPE_W-1:2];
      end else begin : g_narrow_type
         assign exec_only = 1'b0;
      end
   endgenerate

   always_comb begin
      type_mask = '0;
      if (exec_only) begin
         type_mask[RIGHT_X] = can_x;
      end else begin
         type_mask[RIGHT_R] = can_r;
         type_mask[RIGHT_W] = rtype[0] & can_w;
         type_mask[RIGHT_X] = rtype[1] & can_x;
      end
   end
endmodule

// File: rtl/par_fault_resolve.sv
module par_fault_resolve (
   input  logic [2:0]      type_mask,
   input  logic [1:0]      kind,
   input  logic            dirty,
   input  logic            brk,
   input  logic            reftrap,
   output logic [2:0]      grant,
   output par_pkg::fault_e fault
);
   import par_pkg::*;

   logic [2:0] need;

   always_comb begin
      unique case (kind)
         KIND_READ:  need = 3'b001;
         KIND_WRITE: need = 3'b010;
         KIND_EXEC:  need = 3'b100;
         default:    need = 3'b000;
      endcase
   end

   always_comb begin
      grant = type_mask;
      fault = FLT_NONE;
      if (kind == KIND_NONE) begin
         grant = type_mask;
      end else if ((type_mask & need) == 3'b000) begin
         if (kind == KIND_EXEC)          fault = FLT_INST_PROT;
         else if (type_mask[RIGHT_R])    fault = FLT_DATA_PROT;
         else                            fault = FLT_RIGHTS;
      end else begin
         // lowest priority first, later checks overwrite
         if (!dirty) begin
            if (kind == KIND_WRITE) fault = FLT_DIRTY;
            grant[RIGHT_W] = 1'b0;
         end
         if (brk) begin
            if (kind == KIND_WRITE) fault = FLT_BREAK;
            grant[RIGHT_W] = 1'b0;
         end
         if (reftrap) begin
            if (kind != KIND_EXEC) fault = FLT_REFTRAP;
            grant[RIGHT_R] = 1'b0;
            grant[RIGHT_W] = 1'b0;
         end
      end
   end

   always_comb begin
      if (kind == KIND_NONE)
         AST_NONE_NEVER_FAULTS: assert (fault == FLT_NONE); // R5
   end
endmodule

// File: rtl/par_fault_encode.sv
module par_fault_encode #(
   parameter bit FAULT_ONEHOT = 1'b0,
   parameter int FC_W = FAULT_ONEHOT ? par_pkg::NUM_FAULTS : 3
) (
   input  par_pkg::fault_e  fault,
   output logic [FC_W-1:0]  code
);
   import par_pkg::*;

   generate
      if (FAULT_ONEHOT) begin : g_onehot
         always_comb begin
            code = '0;
            for (int i = 1; i <= NUM_FAULTS; i++) begin
               if (fault == fault_e'(i)) code[i-1] = 1'b1;
            end
         end
         always_comb begin
            AST_CODE_ONEHOT: assert ($onehot0(code)); // R12
         end
      end else begin : g_binary
         assign code = FC_W'(fault);
      end
   endgenerate
endmodule

// File: rtl/par_checker.sv
module par_checker #(
   parameter int PL_W         = 2,
   parameter int TYPE_W       = 3,
   parameter bit FAULT_ONEHOT = 1'b0,
   localparam int FC_W        = FAULT_ONEHOT ? 6 : 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [PL_W-1:0]   cur_pl,
   input  logic [PL_W-1:0]   ent_pl_hi,
   input  logic [PL_W-1:0]   ent_pl_lo,
   input  logic [TYPE_W-1:0] ent_type,
   input  logic              ent_dirty,
   input  logic              ent_break,
   input  logic              ent_reftrap,
   output logic              rsp_valid,
   output logic [2:0]        rsp_grant,
   output logic              rsp_fault,
   output logic [FC_W-1:0]   rsp_code
);
   import par_pkg::*;

   generate
      if (PL_W < 1) begin : g_bad_pl
         $error("PL_W must be at least 1");
      end
      if (TYPE_W < 3) begin : g_bad_type
         $error("TYPE_W must be at least 3");
      end
   endgenerate

   logic [2:0]      type_mask;
   logic [2:0]      grant_d;
   fault_e          fault_d;
   logic [FC_W-1:0] code_d;

   par_rights_decode #(.PL_W(PL_W), .TYPE_W(TYPE_W)) rights_i (
      .cur_pl(cur_pl), .pl_hi(ent_pl_hi), .pl_lo(ent_pl_lo),
      .rtype(ent_type), .type_mask(type_mask)
   );

   par_fault_resolve resolve_i (
      .type_mask(type_mask), .kind(req_kind), .dirty(ent_dirty),
      .brk(ent_break), .reftrap(ent_reftrap),
      .grant(grant_d), .fault(fault_d)
   );

   par_fault_encode #(.FAULT_ONEHOT(FAULT_ONEHOT), .FC_W(FC_W)) encode_i (
      .fault(fault_d), .code(code_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= '0;
         rsp_fault <= 1'b0;
         rsp_code  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_grant <= grant_d;
            rsp_fault <= (fault_d != FLT_NONE);
            rsp_code  <= code_d;
         end
      end
   end

   AST_NONE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_NONE) |=> !rsp_fault); // R5
   AST_READ_CLEAN_HAS_R: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_READ) |=> (rsp_fault || rsp_grant[RIGHT_R])); // R1
   AST_WRITE_CLEAN_HAS_W: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_WRITE) |=> (rsp_fault || rsp_grant[RIGHT_W])); // R2
   AST_EXEC_CLEAN_HAS_X: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_EXEC) |=> (rsp_fault || rsp_grant[RIGHT_X])); // R3
   AST_DIRTY_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_WRITE && !ent_dirty) |=> rsp_fault); // R7
   AST_BREAK_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_WRITE && ent_break) |=> rsp_fault); // R8
   AST_REFTRAP_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == KIND_EXEC && ent_reftrap) |=> (rsp_fault || rsp_grant == 3'b100)); // R9
   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R10
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(rsp_grant) && $stable(rsp_code))); // R10
   AST_FAULT_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault == (rsp_code != '0)); // R11
endmodule

// File: tb/par_checker_tb_top.sv
module par_checker_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic [1:0] cur_pl = '0, ent_pl_hi = '0, ent_pl_lo = '0;
   logic [2:0] ent_type = '0;
   logic ent_dirty = 1'b0, ent_break = 1'b0, ent_reftrap = 1'b0;

   logic       rv_a, rv_b, f_a, f_b;
   logic [2:0] g_a, g_b, c_a;
   logic [5:0] c_b;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk; // 50 MHz

   par_checker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .cur_pl(cur_pl), .ent_pl_hi(ent_pl_hi), .ent_pl_lo(ent_pl_lo),
      .ent_type(ent_type), .ent_dirty(ent_dirty), .ent_break(ent_break),
      .ent_reftrap(ent_reftrap), .rsp_valid(rv_a), .rsp_grant(g_a),
      .rsp_fault(f_a), .rsp_code(c_a)
   );

   par_checker #(.FAULT_ONEHOT(1'b1)) dut_oh_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .cur_pl(cur_pl), .ent_pl_hi(ent_pl_hi), .ent_pl_lo(ent_pl_lo),
      .ent_type(ent_type), .ent_dirty(ent_dirty), .ent_break(ent_break),
      .ent_reftrap(ent_reftrap), .rsp_valid(rv_b), .rsp_grant(g_b),
      .rsp_fault(f_b), .rsp_code(c_b)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic void ref_model(input int pl, pl1, pl2, typ, kind, d, b, t,
                                     output int g, output int code, output string tag);
      int r, w, x, m, need;
      r = (pl <= pl1); w = (pl <= pl2); x = (pl2 <= pl) && (pl <= pl1);
      case (typ)
         0: m = r;
         1: m = r | (w << 1);
         2: m = r | (x << 2);
         3: m = r | (w << 1) | (x << 2);
         default: m = x << 2;
      endcase
      code = 0;
      need = (kind == 1) ? 1 : (kind == 2) ? 2 : 4;
      if (kind == 0) begin
         tag = "R5";
      end else if ((m & need) == 0) begin
         tag = "R6";
         code = (kind == 3) ? 1 : ((m & 1) != 0) ? 2 : 3;
      end else begin
         tag = (kind == 1) ? "R1" : (kind == 2) ? "R2" : "R3";
         if (d == 0) begin if (kind == 2) begin code = 4; tag = "R7"; end m &= 5; end
         if (b != 0) begin if (kind == 2) begin code = 5; tag = "R8"; end m &= 5; end
         if (t != 0) begin if (kind != 3) begin code = 6; tag = "R9"; end m &= 4; end
      end
      g = m;
   endfunction

   int last_g, last_c;

   task automatic apply(input int pl, pl1, pl2, typ, kind, d, b, t);
      int g, code;
      string tag;
      ref_model(pl, pl1, pl2, typ, kind, d, b, t, g, code, tag);
      cur_pl = 2'(pl); ent_pl_hi = 2'(pl1); ent_pl_lo = 2'(pl2);
      ent_type = 3'(typ); req_kind = 2'(kind);
      ent_dirty = 1'(d); ent_break = 1'(b); ent_reftrap = 1'(t);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10", "rsp_valid", int'(rv_a), 1);
      check("R4", "grant", int'(g_a), g);
      check(tag, "code", int'(c_a), code);
      check("R11", "fault flag", int'(f_a), int'(code != 0));
      check("R12", "onehot code", int'(c_b), (code == 0) ? 0 : (1 << (code - 1)));
      check("R12", "onehot grant", int'(g_b), g);
      last_g = g; last_c = code;
   endtask

   task automatic idle_check();
      cur_pl = 2'($urandom); ent_type = 3'($urandom); req_kind = 2'($urandom);
      ent_dirty = 1'($urandom); ent_break = 1'($urandom); ent_reftrap = 1'($urandom);
      @(negedge clk);
      check("R10", "idle rsp_valid", int'(rv_a), 0);
      check("R10", "idle grant hold", int'(g_a), last_g);
      check("R10", "idle code hold", int'(c_a), last_c);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      check("R11", "reset rsp_valid", int'(rv_a), 0);
      check("R11", "reset grant", int'(g_a), 0);
      check("R11", "reset fault", int'(f_a), 0);
      check("R11", "reset code", int'(c_a), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners: priority stacking on a fully permitted write / read
      apply(0, 3, 3, 3, 2, 0, 1, 1); // R9 over R8 over R7
      apply(0, 3, 3, 3, 2, 0, 1, 0); // R8 over R7
      apply(0, 3, 3, 3, 2, 0, 0, 0); // R7
      apply(2, 3, 1, 7, 3, 1, 0, 1); // R3 exec-only promoted type with trap bit
      idle_check();
      // exhaustive sweep
      for (int k = 0; k < 16384; k++) begin
         apply(k & 3, (k >> 2) & 3, (k >> 4) & 3, (k >> 6) & 7,
               (k >> 9) & 3, (k >> 11) & 1, (k >> 12) & 1, (k >> 13) & 1);
      end
      // random with idle gaps
      for (int n = 0; n < 2000; n++) begin
         apply($urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(7),
               $urandom_range(3), $urandom_range(1), $urandom_range(1), $urandom_range(1));
         if ($urandom_range(3) == 0) idle_check();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule